// File: doc/BRIEF.md
# Sparse Token Compaction Funnel

The funnel takes a wide row of emitter outputs, most of which are empty in any given cycle. It repacks the occupied entries onto a narrow row of output channels that feed delivery lines. Each token is a pair: a log weight and a target lane number. The funnel never changes either field. There is no backpressure. Every token reaches the output exactly `STAGES = N_IN / N_OUT` cycles after it was presented, or it is dropped and counted.

Inside, the inputs are split into `STAGES` groups of `N_OUT` adjacent emitters. A chain of `STAGES` slot registers carries the tokens of one input cycle toward the output. Group g waits g cycles in a skew delay line, then joins the chain at stage g. It drops into the first empty slots it finds.

Each slot is a two-state machine with the states EMPTY and HELD:
- The *fill* transition (EMPTY to HELD) happens when a merging token claims the slot.
- The *pass* transition copies the state of the upstream slot one stage forward.
- The *drain* transition happens when a HELD slot leaves the last stage and that stage takes in an EMPTY one.

A token that finds no free slot is discarded, and the drop counter advances.

Top module: `emission_funnel`

## Requirements
- R1: After reset every `out_valid` bit is 0 and `drop_count` is 0, and the outputs stay empty until tokens presented after reset arrive.
- R2: A token presented in cycle t appears at the outputs in cycle t+STAGES, for every input position; STAGES = N_IN/N_OUT.
- R3: The occupied outputs of a cycle form a contiguous run starting at slot 0. Tokens are placed in ascending order of their input index, so the token with the k-th lowest occupied input index appears on output slot k.
- R4: At most N_OUT tokens leave per cycle. When more than N_OUT inputs were occupied in one cycle, the N_OUT lowest-indexed ones are kept and the rest are discarded.
- R5: `drop_count` increases by the number of discarded tokens and wraps modulo 2^CNT_W. After the pipeline drains, it equals the total discarded so far.
- R6: The weight and the lane of a delivered token equal the values presented with it. Input token i occupies bits `[i*WT_W +: WT_W]` of `in_weight` and bits `[i*LANE_W +: LANE_W]` of `in_lane`; output slot k uses the same layout.
- R7: Tokens from different input cycles never share an output cycle. A cycle with no occupied input gives a cycle with all `out_valid` bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N_IN | Occupancy flag of each emitter position |
| in_weight | input | N_IN*WT_W | Log weights, one field per position |
| in_lane | input | N_IN*LANE_W | Target lanes, one field per position |
| out_valid | output | N_OUT | Occupancy flag of each output channel |
| out_weight | output | N_OUT*WT_W | Log weights on the output channels |
| out_lane | output | N_OUT*LANE_W | Target lanes on the output channels |
| drop_count | output | CNT_W | Running count of discarded tokens |

## Verification
Suppose a slot state machine sticks in HELD or misses a fill. The bad value shows on `out_valid` exactly STAGES cycles after the input cycle it belongs to, as a hole in the run from slot 0 or as a slot that should be occupied but is empty. A bad skew delay or a bad merge order moves a weight or lane onto the wrong slot in that same output cycle. A wrong count of discarded tokens shows as a `drop_count` mismatch once the chain drains, STAGES cycles after the last occupied input.

// File: rtl/funnel_pkg.sv
package funnel_pkg;
    // Occupancy of one slot in the compaction chain
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_e;
endpackage

// File: rtl/fnl_skew.sv
module fnl_skew #(
    parameter int DEPTH = 1,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] tap_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int d = 0; d < DEPTH; d++) tap_q[d] <= '0;
        end else begin
            tap_q[0] <= din;
            for (int d = 1; d < DEPTH; d++) tap_q[d] <= tap_q[d-1];
        end
    end

    assign dout = tap_q[DEPTH-1];
endmodule

// File: rtl/fnl_merge_stage.sv
module fnl_merge_stage
    import funnel_pkg::*;
#(
    parameter int N_SLOT = 4,
    parameter int TOK_W  = 12,
    parameter int DROP_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_SLOT-1:0]         prev_v,
    input  logic [N_SLOT*TOK_W-1:0]   prev_t,
    input  logic [N_SLOT-1:0]         grp_v,
    input  logic [N_SLOT*TOK_W-1:0]   grp_t,
    output logic [N_SLOT-1:0]         slot_v,
    output logic [N_SLOT*TOK_W-1:0]   slot_t,
    output logic [DROP_W-1:0]         drop_n
);
    slot_state_e               slot_q  [N_SLOT];
    slot_state_e               nxt_st  [N_SLOT];
    logic [N_SLOT*TOK_W-1:0]   nxt_t;
    logic [N_SLOT*TOK_W-1:0]   data_q;
    logic                      placed;

    // First-fit merge: group tokens in index order take the lowest empty slots
    always_comb begin
        for (int s = 0; s < N_SLOT; s++)
            nxt_st[s] = prev_v[s] ? SLOT_HELD : SLOT_EMPTY;
        nxt_t  = prev_t;
        drop_n = '0;
        placed = 1'b0;
        for (int j = 0; j < N_SLOT; j++) begin
            if (grp_v[j]) begin
                placed = 1'b0;
                for (int s = 0; s < N_SLOT; s++) begin
                    unique case (nxt_st[s])
                        SLOT_EMPTY: if (!placed) begin
                            nxt_st[s] = SLOT_HELD;
                            nxt_t[s*TOK_W +: TOK_W] = grp_t[j*TOK_W +: TOK_W];
                            placed = 1'b1;
                        end
                        SLOT_HELD: ;
                    endcase
                end
                if (!placed) drop_n = drop_n + DROP_W'(1);
            end
        end
    end

    // State register: fill / pass / drain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < N_SLOT; s++) slot_q[s] <= SLOT_EMPTY;
        end else begin
            for (int s = 0; s < N_SLOT; s++) slot_q[s] <= nxt_st[s];
        end
    end

    // Token data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= nxt_t;
    end

    always_comb begin
        for (int s = 0; s < N_SLOT; s++) slot_v[s] = (slot_q[s] == SLOT_HELD);
    end
    assign slot_t = data_q;

    // R4
    keep_upstream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(slot_v) >= $past($countones(prev_v)));

    // R4
    drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_n != '0) |=> (&slot_v));

    generate
        for (genvar s = 0; s + 1 < N_SLOT; s++) begin : g_prefix
            // R3
            no_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(!slot_v[s] && slot_v[s+1]));
        end
    endgenerate
endmodule

// File: rtl/emission_funnel.sv
module emission_funnel #(
    parameter int N_IN   = 16,
    parameter int N_OUT  = 4,
    parameter int WT_W   = 8,
    parameter int LANE_W = 4,
    parameter int CNT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_IN-1:0]          in_valid,
    input  logic [N_IN*WT_W-1:0]     in_weight,
    input  logic [N_IN*LANE_W-1:0]   in_lane,
    output logic [N_OUT-1:0]         out_valid,
    output logic [N_OUT*WT_W-1:0]    out_weight,
    output logic [N_OUT*LANE_W-1:0]  out_lane,
    output logic [CNT_W-1:0]         drop_count
);
    localparam int STAGES = N_IN / N_OUT;
    localparam int TOK_W  = WT_W + LANE_W;
    localparam int DROP_W = $clog2(N_OUT + 1);
    localparam int SUM_W  = DROP_W + $clog2(STAGES + 1);
    localparam int GRP_W  = N_OUT + N_OUT * TOK_W;

    logic [N_OUT*TOK_W-1:0] grp_tok  [STAGES];
    logic [N_OUT-1:0]       dly_v    [STAGES];
    logic [N_OUT*TOK_W-1:0] dly_t    [STAGES];
    logic [N_OUT-1:0]       stg_v    [STAGES];
    logic [N_OUT*TOK_W-1:0] stg_t    [STAGES];
    logic [DROP_W-1:0]      drop_n   [STAGES];
    logic [SUM_W-1:0]       drop_total;
    logic [CNT_W-1:0]       drop_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            for (genvar j = 0; j < N_OUT; j++) begin : g_pack
                assign grp_tok[g][j*TOK_W +: TOK_W] =
                    {in_weight[(g*N_OUT+j)*WT_W +: WT_W],
                     in_lane[(g*N_OUT+j)*LANE_W +: LANE_W]};
            end

            if (g == 0) begin : g_direct
                assign dly_v[g] = in_valid[N_OUT-1:0];
                assign dly_t[g] = grp_tok[g];
                fnl_merge_stage #(.N_SLOT(N_OUT), .TOK_W(TOK_W), .DROP_W(DROP_W)) u_merge (
                    .clk(clk), .rst_n(rst_n),
                    .prev_v('0), .prev_t('0),
                    .grp_v(dly_v[g]), .grp_t(dly_t[g]),
                    .slot_v(stg_v[g]), .slot_t(stg_t[g]), .drop_n(drop_n[g]));
            end else begin : g_delayed
                fnl_skew #(.DEPTH(g), .WIDTH(GRP_W)) u_skew (
                    .clk(clk), .rst_n(rst_n),
                    .din({in_valid[g*N_OUT +: N_OUT], grp_tok[g]}),
                    .dout({dly_v[g], dly_t[g]}));
                fnl_merge_stage #(.N_SLOT(N_OUT), .TOK_W(TOK_W), .DROP_W(DROP_W)) u_merge (
                    .clk(clk), .rst_n(rst_n),
                    .prev_v(stg_v[g-1]), .prev_t(stg_t[g-1]),
                    .grp_v(dly_v[g]), .grp_t(dly_t[g]),
                    .slot_v(stg_v[g]), .slot_t(stg_t[g]), .drop_n(drop_n[g]));
            end
        end

        for (genvar k = 0; k < N_OUT; k++) begin : g_unpack
            assign out_weight[k*WT_W +: WT_W] = stg_t[STAGES-1][k*TOK_W + LANE_W +: WT_W];
            assign out_lane[k*LANE_W +: LANE_W] = stg_t[STAGES-1][k*TOK_W +: LANE_W];
        end
    endgenerate

    always_comb begin
        drop_total = '0;
        for (int g = 0; g < STAGES; g++) drop_total = drop_total + SUM_W'(drop_n[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drop_q <= '0;
        else        drop_q <= drop_q + CNT_W'(drop_total);
    end

    assign out_valid  = stg_v[STAGES-1];
    assign drop_count = drop_q;

    // R5
    count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_total == '0) |=> (drop_count == $past(drop_count)));
endmodule

// File: tb/emission_funnel_bench.sv
module emission_funnel_bench;
    localparam int BN = 16, BM = 4, BW = 8, BLW = 4, BCW = 8;
    localparam int BL = BN / BM;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [BN-1:0]     in_valid = '0;
    logic [BN*BW-1:0]  in_weight = '0;
    logic [BN*BLW-1:0] in_lane = '0;
    logic [BM-1:0]     out_valid;
    logic [BM*BW-1:0]  out_weight;
    logic [BM*BLW-1:0] out_lane;
    logic [BCW-1:0]    drop_count;

    int n_chk = 0, n_bad = 0, step_k = 0;
    bit done = 1'b0;
    logic [BCW-1:0] exp_drops = '0;
    logic [BM-1:0]  rv [8];
    logic [BW-1:0]  rw [8][BM];
    logic [BLW-1:0] rl [8][BM];
    string          rtag [8];

    always #2 clk = ~clk;

    emission_funnel #(.N_IN(BN), .N_OUT(BM), .WT_W(BW), .LANE_W(BLW), .CNT_W(BCW)) u_emission_funnel (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_weight(in_weight), .in_lane(in_lane),
        .out_valid(out_valid), .out_weight(out_weight), .out_lane(out_lane), .drop_count(drop_count));

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Compare the outputs due now, then present the next input row
    task automatic step(logic [BN-1:0] mask, string tag);
        int old, cur, filled;
        @(negedge clk);
        old = (step_k + 8 - BL) % 8;
        cur = step_k % 8;
        for (int s = 0; s < BM; s++) begin
            check(rtag[old], $sformatf("valid slot %0d", s), int'(out_valid[s]), int'(rv[old][s]));
            if (rv[old][s]) begin
                check("R6", $sformatf("weight slot %0d", s), int'(out_weight[s*BW +: BW]), int'(rw[old][s]));
                check("R6", $sformatf("lane slot %0d", s), int'(out_lane[s*BLW +: BLW]), int'(rl[old][s]));
            end
        end
        rv[cur] = '0;
        rtag[cur] = tag;
        filled = 0;
        for (int i = 0; i < BN; i++) begin
            logic [BW-1:0]  w;
            logic [BLW-1:0] l;
            w = BW'((step_k * 37 + i * 11) ^ 8'h5A);
            l = BLW'(step_k + 3 * i);
            in_weight[i*BW +: BW] = w;
            in_lane[i*BLW +: BLW] = l;
            if (mask[i]) begin
                if (filled < BM) begin
                    rv[cur][filled] = 1'b1;
                    rw[cur][filled] = w;
                    rl[cur][filled] = l;
                    filled++;
                end else begin
                    exp_drops = exp_drops + 1'b1;
                end
            end
        end
        in_valid = mask;
        step_k++;
    endtask

    task automatic drain_and_count();
        for (int d = 0; d <= BL; d++) step('0, "R7");
        check("R5", "drop_count", int'(drop_count), int'(exp_drops));
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] x;
        for (int e = 0; e < 8; e++) begin
            rv[e] = '0;
            rtag[e] = "R1";
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "out_valid in reset", int'(out_valid), 0);
        check("R1", "drop_count in reset", int'(drop_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_valid after reset", int'(out_valid), 0);
        check("R1", "drop_count after reset", int'(drop_count), 0);

        // R7 empty rows and isolation between full rows
        for (int r = 0; r < 4; r++) step('0, "R7");
        step('1, "R7"); step('0, "R7"); step('1, "R7"); step('0, "R7");
        drain_and_count();

        // R2 every single position
        for (int i = 0; i < BN; i++) step(BN'(1) << i, "R2");
        drain_and_count();

        // R3 every pair of positions
        for (int i = 0; i < BN; i++)
            for (int j = i + 1; j < BN; j++)
                step((BN'(1) << i) | (BN'(1) << j), "R3");
        drain_and_count();

        // R4 dense pseudo-random rows, overflow frequent; drops wrap the counter
        x = 32'h1234_5678;
        for (int r = 0; r < 1500; r++) begin
            x = x * 32'd1103515245 + 32'd12345;
            if (r % 3 == 0) step(BN'(x >> 8) & BN'(x >> 16), "R4");
            else            step(BN'(x >> 10), "R4");
        end
        drain_and_count();

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule